// File: doc/BRIEF.md
# Shift-and-Add Result Output Stage

This block sits behind a row of multiply-accumulate cells. It either passes one chosen cell result out to a shared result bus or combines several results in a 26-bit output buffer. On every clock the buffer is reloaded. The new value is the chosen cell result plus one of two feedback operands: zero, or the buffer's own upper 18 bits taken as a sign-extended arithmetic right shift by 8. Running that recurrence over a sequence of cells adds 8x8 partial products of wider words with the correct weights.

The address, the shift-add control and the two clear controls are all registered once before they act. A one-bit history of the registered shift-add control drives the output multiplexer. The cell value is shown only after two consecutive clocks with shift-add low, and the buffer is shown otherwise. When an address stays the same over several clocks, the stage keeps the cell value it captured on that address's first clock, so the bus stays steady for a slow reader. The two halves of the result bus each have an active-low enable. A disabled half reads as zero, and a flag shows whether that half is driven.

Top module: `sa_output_stage`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, the buffer and all control history are cleared, so with both bus enables active `sum_o` reads 0.
- R2: `addr_i`, `shadd_i`, `reset_n_i` and `erase_n_i` are sampled on a rising edge and act only from the following clock (one clock of internal delay).
- R3: When the registered shift-add is low, the buffer loads the selected cell result unchanged.
- R4: When the registered shift-add is high, the buffer loads the selected cell result plus buffer bits [25:8] sign-extended to 26 bits; the low 8 buffer bits are dropped.
- R5: `sum_o` carries the selected cell result only when the registered shift-add is low and was also low on the clock before; otherwise it carries the buffer.
- R6: The selected cell result is the value of cell `addr_q` (bits [26*addr_q +: 26] of `cells_i`) captured on the first clock after `addr_q` takes a new value, and on the first clock after reset; while the address stays the same, later changes of that cell are not shown.
- R7: When `reset_n_i` and `erase_n_i` are both sampled low, the buffer is cleared to 0 on the next clock edge.
- R8: Either `reset_n_i` or `erase_n_i` low on its own leaves the buffer recurrence unchanged.
- R9: `lo_en_n_i` high forces `sum_o[15:0]` to 0 and drops `lo_drv_o`; when low, those bits carry the result and `lo_drv_o` is 1.
- R10: `hi_en_n_i` high forces `sum_o[25:16]` to 0 and drops `hi_drv_o`; when low, those bits carry the result and `hi_drv_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cells_i | input | 208 | Eight 26-bit cell results, cell k at bits [26k +: 26] |
| addr_i | input | 3 | Cell address (registered before use) |
| shadd_i | input | 1 | Shift-add control: 1 feeds back the shifted buffer (registered) |
| reset_n_i | input | 1 | Functional reset, active low (registered) |
| erase_n_i | input | 1 | Erase, active low; with reset_n_i clears the buffer (registered) |
| lo_en_n_i | input | 1 | Active-low enable for result bits 15:0 |
| hi_en_n_i | input | 1 | Active-low enable for result bits 25:16 |
| sum_o | output | 26 | Result bus |
| lo_drv_o | output | 1 | Low half driven flag |
| hi_drv_o | output | 1 | High half driven flag |

## Verification
The checker enforces four rules on every clock. A disabled bus half must read zero. A both-low clear must show an empty buffer on the following clock when the buffer is on the bus. After two low shift-add clocks on a new address, the output must equal the freshly addressed cell. On an unchanged address the output must stay constant. The arithmetic of the shift-add recurrence needs the bench's scenarios to show it: the sign extension of the fed-back operand, the one-clock lag of the address and control inputs, the buffer staying visible for the clock after shift-add falls, and single clears that have no effect. The bench runs hand-worked sequences with literal results, then a long pseudo-random sweep over address, controls, enables and cell values, compared against an arithmetic model.

// File: rtl/sa_output_stage_pkg.sv
package sa_output_stage_pkg;
  localparam int unsigned SAS_NCELL = 8;
  localparam int unsigned SAS_W     = 26;
  localparam int unsigned SAS_SHIFT = 8;
  localparam int unsigned SAS_LO_W  = 16;

  typedef enum logic {
    FB_ZERO  = 1'b0,
    FB_SHIFT = 1'b1
  } fb_sel_e;

  typedef enum logic {
    OUT_BUF  = 1'b0,
    OUT_CELL = 1'b1
  } out_sel_e;
endpackage

// File: rtl/sa_ctrl_pipe.sv
module sa_ctrl_pipe #(
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          shadd_i,
  input  logic          reset_n_i,
  input  logic          erase_n_i,
  output logic [AW-1:0] addr_q,
  output logic          new_addr_q,
  output logic          sh_q,
  output logic          sh_qq,
  output logic          clr_q
);
  logic          valid_q;
  logic [AW-1:0] addr_d;
  logic          new_addr_d;
  logic          sh_d;
  logic          sh_dd;
  logic          clr_d;
  logic          valid_d;

  always_comb begin
    addr_d     = addr_i;
    new_addr_d = (!valid_q) || (addr_i != addr_q);
    sh_d       = shadd_i;
    sh_dd      = sh_q;
    clr_d      = (!reset_n_i) && (!erase_n_i);
    valid_d    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      new_addr_q <= 1'b0;
      sh_q       <= 1'b0;
      sh_qq      <= 1'b0;
      clr_q      <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      addr_q     <= addr_d;
      new_addr_q <= new_addr_d;
      sh_q       <= sh_d;
      sh_qq      <= sh_dd;
      clr_q      <= clr_d;
      valid_q    <= valid_d;
    end
  end
endmodule

// File: rtl/sa_cell_pick.sv
module sa_cell_pick #(
  parameter int unsigned NCELL = 8,
  parameter int unsigned W     = 26,
  parameter int unsigned AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCELL*W-1:0] cells_i,
  input  logic [AW-1:0]    addr_q,
  input  logic             new_addr_q,
  output logic [W-1:0]     cell_sel
);
  logic [W-1:0] cell_arr [NCELL];
  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;
  logic         hold_en;

  for (genvar g = 0; g < NCELL; g++) begin : g_split
    assign cell_arr[g] = cells_i[g*W +: W];
  end

  always_comb begin
    cell_sel = new_addr_q ? cell_arr[addr_q] : hold_q;
    hold_en  = new_addr_q;
    hold_d   = cell_arr[addr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/sa_accum.sv
module sa_accum
  import sa_output_stage_pkg::*;
#(
  parameter int unsigned W     = 26,
  parameter int unsigned SHIFT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cell_sel,
  input  logic         sh_q,
  input  logic         clr_q,
  output logic [W-1:0] buf_q
);
  localparam int unsigned KEEP = W - SHIFT;

  fb_sel_e      fb_sel;
  logic [W-1:0] fb_shifted;
  logic [W-1:0] fb_operand;
  logic [W-1:0] buf_d;

  always_comb begin
    fb_sel     = sh_q ? FB_SHIFT : FB_ZERO;
    fb_shifted = {{SHIFT{buf_q[W-1]}}, buf_q[W-1 -: KEEP]};
    fb_operand = (fb_sel == FB_SHIFT) ? fb_shifted : '0;
    buf_d      = clr_q ? '0 : (cell_sel + fb_operand);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else begin
      buf_q <= buf_d;
    end
  end
endmodule

// File: rtl/sa_out_drv.sv
module sa_out_drv
  import sa_output_stage_pkg::*;
#(
  parameter int unsigned W    = 26,
  parameter int unsigned LO_W = 16
) (
  input  logic [W-1:0] cell_sel,
  input  logic [W-1:0] buf_q,
  input  logic         sh_q,
  input  logic         sh_qq,
  input  logic         lo_en_n_i,
  input  logic         hi_en_n_i,
  output logic [W-1:0] sum_o,
  output logic         lo_drv_o,
  output logic         hi_drv_o
);
  localparam int unsigned HI_W = W - LO_W;

  out_sel_e     out_sel;
  logic [W-1:0] raw;

  always_comb begin
    out_sel  = (!sh_q && !sh_qq) ? OUT_CELL : OUT_BUF;
    raw      = (out_sel == OUT_CELL) ? cell_sel : buf_q;
    lo_drv_o = !lo_en_n_i;
    hi_drv_o = !hi_en_n_i;
    sum_o[LO_W-1:0] = lo_drv_o ? raw[LO_W-1:0] : '0;
    sum_o[W-1:LO_W] = hi_drv_o ? raw[W-1 -: HI_W] : '0;
  end
endmodule

// File: rtl/sa_output_stage.sv
module sa_output_stage
  import sa_output_stage_pkg::*;
#(
  parameter int unsigned NCELL = SAS_NCELL,
  parameter int unsigned W     = SAS_W,
  parameter int unsigned SHIFT = SAS_SHIFT,
  parameter int unsigned LO_W  = SAS_LO_W,
  parameter int unsigned AW    = $clog2(NCELL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCELL*W-1:0] cells_i,
  input  logic [AW-1:0]      addr_i,
  input  logic               shadd_i,
  input  logic               reset_n_i,
  input  logic               erase_n_i,
  input  logic               lo_en_n_i,
  input  logic               hi_en_n_i,
  output logic [W-1:0]       sum_o,
  output logic               lo_drv_o,
  output logic               hi_drv_o
);
  logic [AW-1:0] addr_q;
  logic          new_addr_q;
  logic          sh_q;
  logic          sh_qq;
  logic          clr_q;
  logic [W-1:0]  cell_sel;
  logic [W-1:0]  buf_q;

  sa_ctrl_pipe #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .shadd_i    (shadd_i),
    .reset_n_i  (reset_n_i),
    .erase_n_i  (erase_n_i),
    .addr_q     (addr_q),
    .new_addr_q (new_addr_q),
    .sh_q       (sh_q),
    .sh_qq      (sh_qq),
    .clr_q      (clr_q)
  );

  sa_cell_pick #(.NCELL(NCELL), .W(W), .AW(AW)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .cells_i    (cells_i),
    .addr_q     (addr_q),
    .new_addr_q (new_addr_q),
    .cell_sel   (cell_sel)
  );

  sa_accum #(.W(W), .SHIFT(SHIFT)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .cell_sel (cell_sel),
    .sh_q     (sh_q),
    .clr_q    (clr_q),
    .buf_q    (buf_q)
  );

  sa_out_drv #(.W(W), .LO_W(LO_W)) u_drv (
    .cell_sel  (cell_sel),
    .buf_q     (buf_q),
    .sh_q      (sh_q),
    .sh_qq     (sh_qq),
    .lo_en_n_i (lo_en_n_i),
    .hi_en_n_i (hi_en_n_i),
    .sum_o     (sum_o),
    .lo_drv_o  (lo_drv_o),
    .hi_drv_o  (hi_drv_o)
  );
endmodule

// File: rtl/sa_output_stage_chk.sv
module sa_output_stage_chk #(
  parameter int unsigned NCELL = 8,
  parameter int unsigned W     = 26,
  parameter int unsigned LO_W  = 16,
  parameter int unsigned AW    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCELL*W-1:0] cells_i,
  input logic [AW-1:0]      addr_i,
  input logic               shadd_i,
  input logic               reset_n_i,
  input logic               erase_n_i,
  input logic               lo_en_n_i,
  input logic               hi_en_n_i,
  input logic [W-1:0]       sum_o,
  input logic               lo_drv_o,
  input logic               hi_drv_o
);
  logic [2:0]    age_q;
  logic [AW-1:0] a_d1;
  logic [W-1:0]  exp_cell;
  logic          clr_now;
  logic          both_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
      a_d1  <= '0;
    end else begin
      if (age_q != 3'd7) age_q <= age_q + 3'd1;
      a_d1 <= addr_i;
    end
  end

  always_comb begin
    exp_cell = cells_i[a_d1*W +: W];
    clr_now  = !reset_n_i && !erase_n_i;
    both_en  = !lo_en_n_i && !hi_en_n_i;
  end

  AST_LO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    lo_en_n_i |-> (sum_o[LO_W-1:0] == '0) && !lo_drv_o); // R9

  AST_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    hi_en_n_i |-> (sum_o[W-1:LO_W] == '0) && !hi_drv_o); // R10

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q >= 3'd3) && $past(clr_now, 2) && $past(shadd_i, 1) && both_en)
      |-> (sum_o == '0)); // R7

  AST_CELL_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q >= 3'd3) && !$past(shadd_i, 1) && !$past(shadd_i, 2) &&
     ($past(addr_i, 1) != $past(addr_i, 2)) && both_en)
      |-> (sum_o == exp_cell)); // R6

  AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q >= 3'd5) && !$past(shadd_i, 1) && !$past(shadd_i, 2) &&
     !$past(shadd_i, 3) && ($past(addr_i, 1) == $past(addr_i, 2)) &&
     both_en && $past(both_en, 1))
      |-> $stable(sum_o)); // R6
endmodule

bind sa_output_stage sa_output_stage_chk #(
  .NCELL(NCELL), .W(W), .LO_W(LO_W), .AW(AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cells_i   (cells_i),
  .addr_i    (addr_i),
  .shadd_i   (shadd_i),
  .reset_n_i (reset_n_i),
  .erase_n_i (erase_n_i),
  .lo_en_n_i (lo_en_n_i),
  .hi_en_n_i (hi_en_n_i),
  .sum_o     (sum_o),
  .lo_drv_o  (lo_drv_o),
  .hi_drv_o  (hi_drv_o)
);

// File: tb/sa_output_stage_tb.sv
`timescale 1ns/1ps
module sa_output_stage_tb;
  localparam int NC = 8;
  localparam int W  = 26;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NC*W-1:0] cells_i;
  logic [2:0]    addr_i;
  logic          shadd_i, reset_n_i, erase_n_i, lo_en_n_i, hi_en_n_i;
  logic [W-1:0]  sum_o;
  logic          lo_drv_o, hi_drv_o;

  logic [W-1:0]  cell_v [NC];
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  // model state
  logic [W-1:0]  m_hold, m_buf;
  logic [2:0]    m_addr;
  logic          m_new, m_valid, m_sh, m_sh2, m_clr;
  logic [31:0]   lfsr;

  always #2 clk = ~clk;

  for (genvar g = 0; g < NC; g++) begin : g_pack
    assign cells_i[g*W +: W] = cell_v[g];
  end

  sa_output_stage u_dut (
    .clk(clk), .rst_n(rst_n), .cells_i(cells_i), .addr_i(addr_i),
    .shadd_i(shadd_i), .reset_n_i(reset_n_i), .erase_n_i(erase_n_i),
    .lo_en_n_i(lo_en_n_i), .hi_en_n_i(hi_en_n_i),
    .sum_o(sum_o), .lo_drv_o(lo_drv_o), .hi_drv_o(hi_drv_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] shr8(input logic [W-1:0] v);
    return {{8{v[W-1]}}, v[W-1:8]};
  endfunction

  function automatic logic [W-1:0] model_out();
    logic [W-1:0] s, r;
    s = m_new ? cell_v[m_addr] : m_hold;
    r = (!m_sh && !m_sh2) ? s : m_buf;
    if (lo_en_n_i) r[15:0] = '0;
    if (hi_en_n_i) r[25:16] = '0;
    return r;
  endfunction

  // one clock: model advance, then compare at falling edge
  task automatic tick(input string req);
    logic [W-1:0] s, nb;
    logic nn;
    s  = m_new ? cell_v[m_addr] : m_hold;
    nb = m_clr ? '0 : (s + (m_sh ? shr8(m_buf) : '0));
    nn = !m_valid || (addr_i != m_addr);
    @(posedge clk);
    m_hold  = s;
    m_buf   = nb;
    m_sh2   = m_sh;
    m_sh    = shadd_i;
    m_clr   = !reset_n_i && !erase_n_i;
    m_new   = nn;
    m_addr  = addr_i;
    m_valid = 1'b1;
    @(negedge clk);
    chk(req, sum_o, model_out());
    chk(req, {24'd0, lo_drv_o, hi_drv_o}, {24'd0, !lo_en_n_i, !hi_en_n_i});
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) tick(req);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    for (int k = 0; k < NC; k++) cell_v[k] = W'(k * 11 + 3);
    addr_i = 3'd0; shadd_i = 1'b0; reset_n_i = 1'b1; erase_n_i = 1'b1;
    lo_en_n_i = 1'b0; hi_en_n_i = 1'b0;
    m_hold = '0; m_buf = '0; m_addr = '0; m_new = 0; m_valid = 0;
    m_sh = 0; m_sh2 = 0; m_clr = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset output", sum_o, '0);
    chk("R1 reset flags", {24'd0, lo_drv_o, hi_drv_o}, 26'd3);
    rst_n = 1'b1;

    // R3/R5/R6: plain path on address 2
    cell_v[2] = 26'h0012345; addr_i = 3'd2;
    ticks(3, "R5 settle");
    chk("R5 cell shown", sum_o, 26'h0012345);
    shadd_i = 1'b1;
    tick("R2 shadd lag");
    chk("R3 buffer plain load", sum_o, 26'h0012345);
    cell_v[3] = 26'd7; addr_i = 3'd3;
    tick("R4 step1");
    chk("R4 shift-add with old address (R2)", sum_o, 26'h0012468);
    tick("R4 step2");
    chk("R4 shift-add new address", sum_o, 26'h000012B);
    shadd_i = 1'b0;
    tick("R5 history");
    chk("R5 buffer still shown after shadd falls", sum_o, 26'd8);
    tick("R5 cell");
    chk("R5 cell shown after two low clocks", sum_o, 26'd7);
    cell_v[3] = 26'd99;
    tick("R6 hold");
    chk("R6 held value", sum_o, 26'd7);
    tick("R6 hold2");
    chk("R6 held value later", sum_o, 26'd7);

    // R4 sign extension: -1 repeatedly converges to -2
    cell_v[5] = '1; addr_i = 3'd5; shadd_i = 1'b1;
    ticks(7, "R4 settle");
    chk("R4 sign-extended feedback", sum_o, 26'h3FFFFFE);

    // R7 clear
    reset_n_i = 1'b0; erase_n_i = 1'b0;
    tick("R7 arm");
    reset_n_i = 1'b1; erase_n_i = 1'b1;
    tick("R7 clear");
    chk("R7 buffer cleared", sum_o, '0);

    // R8 single controls
    cell_v[4] = 26'd5; addr_i = 3'd4;
    ticks(6, "R8 settle");
    chk("R8 steady", sum_o, 26'd5);
    reset_n_i = 1'b0;
    ticks(2, "R8 reset alone");
    chk("R8 reset alone no clear", sum_o, 26'd5);
    reset_n_i = 1'b1; erase_n_i = 1'b0;
    ticks(2, "R8 erase alone");
    chk("R8 erase alone no clear", sum_o, 26'd5);
    erase_n_i = 1'b1;

    // R9/R10 enables on -2 pattern
    addr_i = 3'd5;
    ticks(6, "R9 settle");
    lo_en_n_i = 1'b1;
    #0.5;
    chk("R9 low half off", sum_o, 26'h3FF0000);
    chk("R9 low flag", {25'd0, lo_drv_o}, 26'd0);
    lo_en_n_i = 1'b0; hi_en_n_i = 1'b1;
    #0.5;
    chk("R10 high half off", sum_o, 26'h000FFFE);
    chk("R10 high flag", {25'd0, hi_drv_o}, 26'd0);
    hi_en_n_i = 1'b0;

    // pseudo-random sweep against the arithmetic model (R2..R10)
    lfsr = 32'hACE1_2024;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      addr_i    = (lfsr[4:3] == 2'b00) ? lfsr[2:0] : addr_i;
      shadd_i   = lfsr[7] ^ lfsr[9];
      reset_n_i = !(lfsr[12:10] == 3'b111);
      erase_n_i = !(lfsr[15:13] >= 3'b101);
      lo_en_n_i = (lfsr[19:17] == 3'b000);
      hi_en_n_i = (lfsr[22:20] == 3'b000);
      cell_v[lfsr[26:24]] = {lfsr[31:27] == 5'd0 ? 1'b1 : lfsr[5], lfsr[30:6]};
      tick("R2-sweep R3 R4 R5 R6 R7 R8 R9 R10");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule